// File: doc/BRIEF.md
# Ethernet PHY Power-Down and Reset Sequencer

This block decides, cycle by cycle, whether one Ethernet PHY port is running, held in reset, asleep waiting for line energy, or fully powered down. Register-style inputs drive it: a general power-down bit, an enable for energy-triggered sleep, two self-clearing software reset requests and a configuration reload command. A line activity detector supplies an asynchronous energy input. The block drives enables for the switched power domains, the transmit and receive gates, an internal PHY reset, a strap-reload strobe, a debounced energy status bit and a sticky wake interrupt.

Every return to power, whether the power-down bit is cleared or line energy wakes the port, passes through an automatic PHY reset. The receive path stays gated until that reset completes, so the first frames that arrive during a wake are dropped. Only a chip-level reset or a reload command asks for strap values to be loaded again. Software resets, power-down and wake never do so. The global software reset is timed from a clock-frequency parameter. The reset requested through the PHY control register uses the short internal reset length.

Top module: `phyPwrSeq`

## Requirements
- R1: While `hwRstN` or `porN` is low, and after both rise, `phyRstOut` is high for exactly PHY_RST_CYCLES cycles. `strapLoad` is high from chip reset until the first clock edge after release. The port is then active, with `txEnable`, `rxEnable` and `corePwrEn` high and `wakeIrq`, `energyStatus` and both busy bits low.
- R2: One cycle after `pwrDownBit` is sampled high, `corePwrEn`, `detectPwrEn`, `txEnable`, `rxEnable` and `phyRstOut` are all low. They stay low while the bit stays high.
- R3: One cycle after `pwrDownBit` is sampled low while powered down, `phyRstOut` rises and stays high for PHY_RST_CYCLES cycles. The port is then active.
- R4: When `energySaveEn` is high and `energyStatus` is low in the active state, the port enters sleep one cycle later: `corePwrEn`, `txEnable` and `rxEnable` are low and `detectPwrEn` is high.
- R5: `energyStatus` follows `energyIn` through a two-flop synchronizer and a debounce of DEBOUNCE cycles. A change held steady changes `energyStatus` at the (DEBOUNCE+2)th rising edge after it is applied. A pulse shorter than DEBOUNCE cycles has no effect.
- R6: When `energyStatus` is high while the port is asleep, `phyRstOut` rises one cycle later for PHY_RST_CYCLES cycles. `rxEnable` stays low during that reset, and `wakeIrq` is set.
- R7: `wakeIrq` stays high until a cycle with `intClr` high and no wake event. If a wake event and `intClr` fall in the same cycle, `wakeIrq` ends up high.
- R8: With `energySaveEn` low, the port stays active whatever the line energy. Clearing `energySaveEn` while asleep powers the port up through a PHY_RST_CYCLES reset and leaves `wakeIrq` low.
- R9: A `globalRstReq` pulse sets `globalRstBusy` one cycle later and holds `phyRstOut` high for CLK_KHZ*SW_RST_US/1000 cycles (2550 with the defaults). `globalRstBusy` clears in the same cycle that `phyRstOut` falls.
- R10: A `ctrlRstReq` pulse sets `ctrlRstBusy` one cycle later and holds `phyRstOut` high for PHY_RST_CYCLES cycles. `ctrlRstBusy` clears in the same cycle that `phyRstOut` falls.
- R11: `strapLoad` is high for exactly one cycle after a `cfgReload` pulse, and that pulse also starts a PHY reset. Software resets, power-down, power-up and energy wake never raise `strapLoad`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hwRstN | input | 1 | Chip hardware reset, active low, asynchronous |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| pwrDownBit | input | 1 | General power-down control bit |
| energySaveEn | input | 1 | Enables sleeping when the line carries no energy |
| energyIn | input | 1 | Raw energy indication from the line detector, asynchronous |
| globalRstReq | input | 1 | One-cycle write of the global PHY software reset bit |
| ctrlRstReq | input | 1 | One-cycle write of the PHY control-register reset bit |
| cfgReload | input | 1 | One-cycle configuration reload command |
| intClr | input | 1 | Write-one-to-clear pulse for the wake interrupt |
| corePwrEn | output | 1 | Power enable for the PHY core and datapath domains |
| detectPwrEn | output | 1 | Power enable for the squelch and energy detect domain |
| txEnable | output | 1 | Transmit path enable |
| rxEnable | output | 1 | Receive path enable |
| phyRstOut | output | 1 | Internal PHY reset, active high |
| strapLoad | output | 1 | Strobe to load strap values into the PHY registers |
| energyStatus | output | 1 | Debounced energy status bit |
| wakeIrq | output | 1 | Sticky energy-wake interrupt flag |
| globalRstBusy | output | 1 | Readback of the self-clearing global reset bit |
| ctrlRstBusy | output | 1 | Readback of the self-clearing control reset bit |

## Verification
A wrong sequencer state shows up at the ports within one cycle. Each state has its own pattern on the power, gate and reset outputs, so a missed wake shows as `corePwrEn` staying low, and a skipped power-up reset shows as the transmit gate opening with no reset pulse before it. A faulty reset counter only shows when `phyRstOut` falls, so each reset length is measured edge by edge, both the short one and the 2550-cycle one. An off-by-one in the synchronizer or the debounce shifts `energyStatus` by one edge, so the bench samples that bit on the exact cycle before and after it is expected to change.

// File: rtl/phyPwrPkg.sv
package phyPwrPkg;

  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_RESET  = 2'd1,
    ST_SLEEP  = 2'd2,
    ST_PWRDN  = 2'd3
  } pwrState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadLong;   // start the software-timed long reset
    logic loadShort;  // start the short internal reset
    logic wakeEvt;    // an energy wake is being taken this cycle
    logic rstFinish;  // the running reset ends this cycle
  } seqStb_t;

endpackage

// File: rtl/phyPwrDatapath.sv
module phyPwrDatapath
  import phyPwrPkg::*;
#(
  parameter int DEBOUNCE  = 8,
  parameter int SHORT_CYC = 16,
  parameter int LONG_CYC  = 2550
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    energyIn,
  input  logic    globalRstReq,
  input  logic    ctrlRstReq,
  input  logic    cfgReload,
  input  logic    intClr,
  input  seqStb_t stb,
  output logic    energyOn,
  output logic    rstDone,
  output logic    globalBusy,
  output logic    ctrlBusy,
  output logic    wakeIrq,
  output logic    strapLoad
);

  localparam int CNT_W = $clog2(LONG_CYC + 1);
  localparam int DB_W  = $clog2(DEBOUNCE + 1);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_CYC - 1);
  localparam logic [DB_W-1:0]  DB_LAST    = DB_W'(DEBOUNCE - 1);

  logic [1:0]       syncQ;
  logic             energySync;
  logic [DB_W-1:0]  dbCnt;
  logic [CNT_W-1:0] rstCnt;

  // two-flop synchronizer for the asynchronous line energy input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], energyIn};
  end
  assign energySync = syncQ[1];

  // debounce: the status moves only after DEBOUNCE steady mismatching cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      energyOn <= 1'b0;
      dbCnt    <= '0;
    end else if (energySync == energyOn) begin
      dbCnt <= '0;
    end else if (dbCnt == DB_LAST) begin
      energyOn <= energySync;
      dbCnt    <= '0;
    end else begin
      dbCnt <= dbCnt + 1'b1;
    end
  end

  // reset length counter shared by all reset sources
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              rstCnt <= SHORT_LOAD;
    else if (stb.loadLong)  rstCnt <= LONG_LOAD;
    else if (stb.loadShort) rstCnt <= SHORT_LOAD;
    else if (rstCnt != '0)  rstCnt <= rstCnt - 1'b1;
  end
  assign rstDone = (rstCnt == '0);

  // self-clearing reset bits: a new request wins over the finish strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      globalBusy <= 1'b0;
      ctrlBusy   <= 1'b0;
    end else begin
      if (globalRstReq)       globalBusy <= 1'b1;
      else if (stb.rstFinish) globalBusy <= 1'b0;
      if (ctrlRstReq)         ctrlBusy <= 1'b1;
      else if (stb.rstFinish) ctrlBusy <= 1'b0;
    end
  end

  // sticky wake flag, write-one-to-clear, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wakeIrq <= 1'b0;
    else if (stb.wakeEvt) wakeIrq <= 1'b1;
    else if (intClr)      wakeIrq <= 1'b0;
  end

  // strap reload: high out of chip reset, then one cycle per reload command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strapLoad <= 1'b1;
    else       strapLoad <= cfgReload;
  end

  // R5
  debounce_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (energyOn != $past(energyOn)) |-> ($past(dbCnt) == DB_LAST));

  // R7
  wake_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wakeEvt |=> wakeIrq);

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq && !intClr) |=> wakeIrq);

  // R9
  gbusy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    globalRstReq |=> globalBusy);

  // R10
  cbusy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRstReq |=> ctrlBusy);

endmodule

// File: rtl/phyPwrCtrl.sv
module phyPwrCtrl
  import phyPwrPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    pwrDownBit,
  input  logic    energySaveEn,
  input  logic    energyOn,
  input  logic    globalRstReq,
  input  logic    ctrlRstReq,
  input  logic    cfgReload,
  input  logic    globalBusy,
  input  logic    rstDone,
  output seqStb_t stb,
  output logic    corePwrEn,
  output logic    detectPwrEn,
  output logic    txEnable,
  output logic    rxEnable,
  output logic    phyRstOut
);

  pwrState_e state, nextState;
  logic anyReq, wantLong, doLoad;

  assign anyReq   = globalRstReq | ctrlRstReq | cfgReload;
  assign wantLong = globalRstReq | globalBusy;

  always_comb begin
    nextState     = state;
    doLoad        = 1'b0;
    stb.wakeEvt   = 1'b0;
    stb.rstFinish = 1'b0;
    if (pwrDownBit) begin
      nextState = ST_PWRDN;
    end else begin
      unique case (state)
        ST_PWRDN: begin
          nextState = ST_RESET;
          doLoad    = 1'b1;
        end
        ST_SLEEP: begin
          if (energyOn) begin
            nextState   = ST_RESET;
            doLoad      = 1'b1;
            stb.wakeEvt = 1'b1;
          end else if (!energySaveEn || anyReq) begin
            nextState = ST_RESET;
            doLoad    = 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (anyReq) begin
            nextState = ST_RESET;
            doLoad    = 1'b1;
          end else if (energySaveEn && !energyOn) begin
            nextState = ST_SLEEP;
          end
        end
        ST_RESET: begin
          if (anyReq) begin
            doLoad = 1'b1;
          end else if (rstDone) begin
            nextState     = ST_ACTIVE;
            stb.rstFinish = 1'b1;
          end
        end
      endcase
    end
    stb.loadLong  = doLoad & wantLong;
    stb.loadShort = doLoad & ~wantLong;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RESET;
    else       state <= nextState;
  end

  always_comb begin
    corePwrEn   = (state == ST_ACTIVE) || (state == ST_RESET);
    detectPwrEn = (state != ST_PWRDN);
    txEnable    = (state == ST_ACTIVE);
    rxEnable    = (state == ST_ACTIVE);
    phyRstOut   = (state == ST_RESET);
  end

  // R2
  pwrdn_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownBit |=> (state == ST_PWRDN));

  // R3
  pwrup_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWRDN && !pwrDownBit) |=> (state == ST_RESET));

  // R4
  sleep_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && energySaveEn && !energyOn && !pwrDownBit && !anyReq)
      |=> (state == ST_SLEEP));

  // R6
  wake_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLEEP && energyOn && !pwrDownBit) |=> (state == ST_RESET));

  // R8
  stay_awake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ACTIVE && !energySaveEn && !pwrDownBit && !anyReq)
      |=> (state == ST_ACTIVE));

endmodule

// File: rtl/phyPwrSeq.sv
module phyPwrSeq
  import phyPwrPkg::*;
#(
  parameter int CLK_KHZ        = 25000,
  parameter int SW_RST_US      = 102,
  parameter int PHY_RST_CYCLES = 16,
  parameter int DEBOUNCE       = 8
) (
  input  logic clk,
  input  logic hwRstN,
  input  logic porN,
  input  logic pwrDownBit,
  input  logic energySaveEn,
  input  logic energyIn,
  input  logic globalRstReq,
  input  logic ctrlRstReq,
  input  logic cfgReload,
  input  logic intClr,
  output logic corePwrEn,
  output logic detectPwrEn,
  output logic txEnable,
  output logic rxEnable,
  output logic phyRstOut,
  output logic strapLoad,
  output logic energyStatus,
  output logic wakeIrq,
  output logic globalRstBusy,
  output logic ctrlRstBusy
);

  localparam int LONG_CYC = (CLK_KHZ * SW_RST_US) / 1000;

  logic    rstN;
  logic    energyOn, rstDone;
  seqStb_t stb;

  assign rstN         = hwRstN & porN;
  assign energyStatus = energyOn;

  phyPwrCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .pwrDownBit   (pwrDownBit),
    .energySaveEn (energySaveEn),
    .energyOn     (energyOn),
    .globalRstReq (globalRstReq),
    .ctrlRstReq   (ctrlRstReq),
    .cfgReload    (cfgReload),
    .globalBusy   (globalRstBusy),
    .rstDone      (rstDone),
    .stb          (stb),
    .corePwrEn    (corePwrEn),
    .detectPwrEn  (detectPwrEn),
    .txEnable     (txEnable),
    .rxEnable     (rxEnable),
    .phyRstOut    (phyRstOut)
  );

  phyPwrDatapath #(
    .DEBOUNCE  (DEBOUNCE),
    .SHORT_CYC (PHY_RST_CYCLES),
    .LONG_CYC  (LONG_CYC)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .energyIn     (energyIn),
    .globalRstReq (globalRstReq),
    .ctrlRstReq   (ctrlRstReq),
    .cfgReload    (cfgReload),
    .intClr       (intClr),
    .stb          (stb),
    .energyOn     (energyOn),
    .rstDone      (rstDone),
    .globalBusy   (globalRstBusy),
    .ctrlBusy     (ctrlRstBusy),
    .wakeIrq      (wakeIrq),
    .strapLoad    (strapLoad)
  );

  // R11
  strap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(phyRstOut) && !$past(cfgReload)) |-> !strapLoad);

endmodule

// File: tb/phyPwrSeq_test.sv
module phyPwrSeq_test;

  localparam int CLK_PERIOD = 10;
  localparam int SHORT      = 16;
  localparam int DB         = 8;
  localparam int CLK_KHZ    = 25000;
  localparam int SW_US      = 102;
  localparam int LONG       = (CLK_KHZ * SW_US) / 1000;

  logic clk = 1'b0;
  logic hwRstN, porN, pwrDownBit, energySaveEn, energyIn;
  logic globalRstReq, ctrlRstReq, cfgReload, intClr;
  logic corePwrEn, detectPwrEn, txEnable, rxEnable, phyRstOut, strapLoad;
  logic energyStatus, wakeIrq, globalRstBusy, ctrlRstBusy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  phyPwrSeq #(
    .CLK_KHZ(CLK_KHZ), .SW_RST_US(SW_US), .PHY_RST_CYCLES(SHORT), .DEBOUNCE(DB)
  ) uut (
    .clk(clk), .hwRstN(hwRstN), .porN(porN), .pwrDownBit(pwrDownBit),
    .energySaveEn(energySaveEn), .energyIn(energyIn), .globalRstReq(globalRstReq),
    .ctrlRstReq(ctrlRstReq), .cfgReload(cfgReload), .intClr(intClr),
    .corePwrEn(corePwrEn), .detectPwrEn(detectPwrEn), .txEnable(txEnable),
    .rxEnable(rxEnable), .phyRstOut(phyRstOut), .strapLoad(strapLoad),
    .energyStatus(energyStatus), .wakeIrq(wakeIrq), .globalRstBusy(globalRstBusy),
    .ctrlRstBusy(ctrlRstBusy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts negedge samples with phyRstOut high, starting at the current one
  task automatic measureRst(output int width, output bit sawStrap);
    width = 0;
    sawStrap = 1'b0;
    while (phyRstOut && width < 5000) begin
      width++;
      if (strapLoad) sawStrap = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic testChipReset();
    int w;
    bit s;
    hwRstN = 0; porN = 0;
    step(3);
    porN = 1;
    step(1);
    hwRstN = 1;
    check("R1", "strapLoad at release", strapLoad, 1);
    check("R1", "phyRstOut at release", phyRstOut, 1);
    measureRst(w, s);
    check("R1", "chip reset width", w, SHORT);
    check("R1", "strapLoad after first edge", strapLoad, 0);
    check("R1", "txEnable active", txEnable, 1);
    check("R1", "rxEnable active", rxEnable, 1);
    check("R1", "corePwrEn active", corePwrEn, 1);
    check("R1", "wakeIrq idle", wakeIrq, 0);
    check("R1", "energyStatus idle", energyStatus, 0);
    check("R1", "busy bits idle", {globalRstBusy, ctrlRstBusy}, 0);
  endtask

  task automatic testPowerDown();
    int w;
    bit s;
    pwrDownBit = 1;
    step(1);
    check("R2", "power pattern", {corePwrEn, detectPwrEn, txEnable, rxEnable, phyRstOut}, 0);
    step(5);
    check("R2", "power pattern held", {corePwrEn, detectPwrEn, txEnable, rxEnable}, 0);
    pwrDownBit = 0;
    step(1);
    check("R3", "phyRstOut after power-up", phyRstOut, 1);
    measureRst(w, s);
    check("R3", "power-up reset width", w, SHORT);
    check("R11", "no strap on power-up", int'(s), 0);
    check("R3", "active after power-up", {corePwrEn, txEnable, rxEnable}, 3'b111);
  endtask

  task automatic testEnergyWake();
    int w;
    bit s;
    energySaveEn = 1;
    step(1);
    check("R4", "sleep pattern", {corePwrEn, detectPwrEn, txEnable, rxEnable}, 4'b0100);
    energyIn = 1;
    step(3);
    energyIn = 0;
    step(8);
    check("R5", "short glitch ignored", energyStatus, 0);
    check("R5", "still asleep after glitch", corePwrEn, 0);
    energyIn = 1;
    step(DB + 1);
    check("R5", "status one edge early", energyStatus, 0);
    step(1);
    check("R5", "status at debounce edge", energyStatus, 1);
    check("R6", "core still off before wake", corePwrEn, 0);
    intClr = 1;  // coincides with the wake event
    step(1);
    intClr = 0;
    check("R6", "phyRstOut on wake", phyRstOut, 1);
    check("R6", "rx gated during wake reset", rxEnable, 0);
    check("R7", "wake wins over clear", wakeIrq, 1);
    measureRst(w, s);
    check("R6", "wake reset width", w, SHORT);
    check("R11", "no strap on wake", int'(s), 0);
    check("R6", "active after wake", {txEnable, rxEnable}, 2'b11);
    step(4);
    check("R7", "wakeIrq sticky", wakeIrq, 1);
    intClr = 1;
    step(1);
    intClr = 0;
    check("R7", "wakeIrq cleared", wakeIrq, 0);
  endtask

  task automatic testSaveDisable();
    int w;
    bit s;
    energyIn = 0;
    step(DB + 3);
    check("R4", "sleep after energy loss", {corePwrEn, detectPwrEn, txEnable}, 3'b010);
    energySaveEn = 0;
    step(1);
    check("R8", "reset on disable", phyRstOut, 1);
    measureRst(w, s);
    check("R8", "disable reset width", w, SHORT);
    check("R8", "no irq on disable", wakeIrq, 0);
    step(40);
    check("R8", "stays active without energy", {corePwrEn, txEnable, rxEnable}, 3'b111);
  endtask

  task automatic testGlobalReset();
    int w;
    bit s;
    globalRstReq = 1;
    step(1);
    globalRstReq = 0;
    check("R9", "global busy set", globalRstBusy, 1);
    check("R9", "phyRstOut set", phyRstOut, 1);
    measureRst(w, s);
    check("R9", "global reset width", w, LONG);
    check("R9", "global busy cleared", globalRstBusy, 0);
    check("R11", "no strap on global reset", int'(s), 0);
  endtask

  task automatic testCtrlReset();
    int w;
    bit s;
    ctrlRstReq = 1;
    step(1);
    ctrlRstReq = 0;
    check("R10", "ctrl busy set", ctrlRstBusy, 1);
    measureRst(w, s);
    check("R10", "ctrl reset width", w, SHORT);
    check("R10", "ctrl busy cleared", ctrlRstBusy, 0);
    check("R11", "no strap on ctrl reset", int'(s), 0);
  endtask

  task automatic testReload();
    int w;
    bit s;
    cfgReload = 1;
    step(1);
    cfgReload = 0;
    check("R11", "strapLoad after reload", strapLoad, 1);
    check("R11", "reset after reload", phyRstOut, 1);
    step(1);
    check("R11", "strapLoad one cycle", strapLoad, 0);
    measureRst(w, s);
    check("R11", "reload reset remainder", w, SHORT - 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    hwRstN = 0; porN = 0; pwrDownBit = 0; energySaveEn = 0; energyIn = 0;
    globalRstReq = 0; ctrlRstReq = 0; cfgReload = 0; intClr = 0;
    @(negedge clk);
    testChipReset();
    testPowerDown();
    testEnergyWake();
    testSaveDisable();
    testGlobalReset();
    testCtrlReset();
    testReload();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule